// File: doc/BRIEF.md
# MSI Line Coherence Controller

This block holds the coherence state of a small set of cache lines and runs a directory-based MSI protocol over them. It keeps the three stable states (invalid, shared, modified) and eight transient states. The transient states cover a miss waiting for data, an upgrade waiting for data and invalidation acknowledgements, and an eviction waiting for the directory to confirm its put. Each cycle the surrounding cache logic may present one event, already decoded, for one line. The block looks up that line's state and chooses the next state. It registers a vector of action strobes that tells the cache and network logic what to do: which request or response to send, whether the processor access completed, whether the line or its transaction entry is claimed or released, which input queue to pop, and whether the event must stall at the head of its queue.

Data storage, victim selection, acknowledgement counting and message transport stay outside the block. The block is told directly whether a data response carried pending acknowledgements, and whether an acknowledgement is the last one. An event that the protocol does not define for the current state leaves the state unchanged and raises a protocol error strobe. A query port returns the state and access permission of any line at any time.

Top module: `msi_line_ctrl`

## Requirements
- R1: Reset (synchronous, active-low) puts every line in I. Line state codes: I=0, IS_D=1, IM_AD=2, IM_A=3, S=4, SM_AD=5, SM_A=6, M=7, MI_A=8, SI_A=9, II_A=10. While in reset, act_valid, act_o and proto_err are 0.
- R2: An event is presented on ev_valid, ev_line and ev_code. Codes: Load=0, Store=1, Replacement=2, FwdGetS=3, FwdGetM=4, Inv=5, PutAck=6, DataDirNoAcks=7, DataDirAcks=8, DataOwner=9, InvAck=10, LastInvAck=11; codes 12 to 15 are undefined. The result shows on act_valid/act_o/proto_err one cycle later, and the new line state shows on qry_state from that same cycle on. A cycle with no event gives act_valid=0, act_o=0 and proto_err=0 in the next cycle and changes no state. act_o bit positions: 0 send GetS, 1 send GetM, 2 send PutS, 3 send PutM with data, 4 data to requestor, 5 data to directory, 6 inv-ack to requestor, 7 load done, 8 store done, 9 claim line, 10 release line, 11 claim transaction entry, 12 release transaction entry, 13 pop processor queue, 14 pop forward queue, 15 pop response queue, 16 stall, 17 write fill data.
- R3: In I, a Load goes to IS_D with bits 9, 11, 0, 13. A Store goes to IM_AD with bits 9, 11, 1, 13.
- R4: DataDirNoAcks or DataOwner takes IS_D to S with bits 17, 12, 7, 15. The same events take IM_AD or SM_AD to M with bits 17, 12, 8, 15.
- R5: DataDirAcks takes IM_AD to IM_A and SM_AD to SM_A, with bits 17 and 15. InvAck in IM_AD, IM_A, SM_AD or SM_A keeps the state and gives bit 15 alone. LastInvAck takes IM_A or SM_A to M with bits 12, 8, 15.
- R6: A Load in S, SM_AD, SM_A or M keeps the state and gives bits 7 and 13. A Store in M keeps M and gives bits 8 and 13. A store completes in no other state.
- R7: From S, a Store goes to SM_AD with bits 11, 1, 13. A Replacement goes to SI_A with bit 2 alone. An Inv goes to I with bits 6, 10, 14.
- R8: From M, FwdGetS goes to S with bits 4, 5, 14. FwdGetM goes to I with bits 4, 10, 14. Replacement goes to MI_A with bit 3 alone.
- R9: Inv takes SM_AD to IM_AD and SI_A to II_A, with bits 6 and 14. In MI_A, FwdGetS goes to SI_A with bits 4, 5, 14, and FwdGetM goes to II_A with bits 4 and 14. PutAck in MI_A, SI_A or II_A goes to I with bits 10 and 14.
- R10: These events give bit 16 alone and keep the state: Load, Store, Replacement or Inv in IS_D; Load, Store, Replacement, FwdGetS or FwdGetM in IM_AD or IM_A; Store, Replacement, FwdGetS or FwdGetM in SM_AD or SM_A; Load, Store or Replacement in MI_A, SI_A or II_A.
- R11: Any other state/event pair, and any undefined code, gives proto_err=1 with act_o=0 and leaves the state unchanged.
- R12: qry_perm gives the access permission of the queried line: 2 in M, 1 in S, SM_AD and SM_A, and 0 in all other states.
- R13: An event changes the state of its own line only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_line | input | LINE_W | Line the event applies to |
| ev_code | input | 4 | Decoded event code |
| qry_line | input | LINE_W | Line whose state is read out |
| act_valid | output | 1 | act_o and proto_err describe the event of the previous cycle |
| act_o | output | 18 | Action strobes |
| proto_err | output | 1 | The previous event is undefined for its line's state |
| qry_state | output | 4 | Current state code of qry_line |
| qry_perm | output | 2 | Access permission of qry_line |

## Verification
Every event has exactly one registered result. act_valid, act_o and proto_err change at the first rising edge after the event is presented. The line's new state can be read on qry_state right after that same edge. The bench presents each event on a falling edge and samples at the next falling edge: it checks the strobes and then reads every line through the query port. A bench model steps in lockstep, one event per cycle, so the comparison happens every clock. Idle cycles are checked the same way to confirm that nothing is emitted.

// File: rtl/msi_pkg.sv
// Package: shared codes and the action strobe record for the MSI line controller.
// Assumes 4-bit state and event codes; the field order of msi_act_t fixes the act_o bit positions.
package msi_pkg;

    localparam int ST_W  = 4;
    localparam int EV_W  = 4;
    localparam int ACT_W = 18;

    typedef enum logic [ST_W-1:0] {
        ST_I     = 4'd0,
        ST_IS_D  = 4'd1,
        ST_IM_AD = 4'd2,
        ST_IM_A  = 4'd3,
        ST_S     = 4'd4,
        ST_SM_AD = 4'd5,
        ST_SM_A  = 4'd6,
        ST_M     = 4'd7,
        ST_MI_A  = 4'd8,
        ST_SI_A  = 4'd9,
        ST_II_A  = 4'd10
    } line_st_e;

    typedef enum logic [EV_W-1:0] {
        EV_LOAD    = 4'd0,
        EV_STORE   = 4'd1,
        EV_REPL    = 4'd2,
        EV_FWD_S   = 4'd3,
        EV_FWD_M   = 4'd4,
        EV_INV     = 4'd5,
        EV_PUT_ACK = 4'd6,
        EV_DATA_NA = 4'd7,
        EV_DATA_A  = 4'd8,
        EV_DATA_OW = 4'd9,
        EV_INV_ACK = 4'd10,
        EV_LAST_IA = 4'd11
    } line_ev_e;

    // Most significant field first: fill is bit 17, req_gets is bit 0.
    typedef struct packed {
        logic fill;
        logic stall;
        logic pop_rsp;
        logic pop_fwd;
        logic pop_cpu;
        logic txn_free;
        logic txn_alloc;
        logic line_free;
        logic line_alloc;
        logic store_done;
        logic load_done;
        logic inv_ack;
        logic data_dir;
        logic data_req;
        logic req_putm;
        logic req_puts;
        logic req_getm;
        logic req_gets;
    } msi_act_t;

    // Access permission of a state: 2 read-write, 1 read-only, 0 none.
    function automatic logic [1:0] perm_of(logic [ST_W-1:0] st);
        case (st)
            ST_M:                    perm_of = 2'd2;
            ST_S, ST_SM_AD, ST_SM_A: perm_of = 2'd1;
            default:                 perm_of = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/msi_state_array.sv
// Module: per-line state registers with one write port and two read ports.
// Assumes line indices below NUM_LINES; one line is written per cycle at most.
module msi_state_array
    import msi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int LINE_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [LINE_W-1:0]         wr_line,
    input  logic [ST_W-1:0]           wr_st,
    input  logic [LINE_W-1:0]         rd_a_line,
    output logic [ST_W-1:0]           rd_a_st,
    input  logic [LINE_W-1:0]         rd_b_line,
    output logic [ST_W-1:0]           rd_b_st,
    output logic [NUM_LINES*ST_W-1:0] st_all
);

    logic [ST_W-1:0] st_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Hold one line's state; load it when this line is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g] <= ST_I;
            end else if (wr_en && (wr_line == LINE_W'(g))) begin
                st_q[g] <= wr_st;
            end
        end
        assign st_all[g*ST_W +: ST_W] = st_q[g];
    end

    // Read ports: the event's line and the query line.
    always_comb begin
        rd_a_st = st_q[rd_a_line];
        rd_b_st = st_q[rd_b_line];
    end

endmodule

// File: rtl/msi_next.sv
// Module: combinational transition function of the MSI line protocol.
// Assumes the event is already decoded; an undefined pair raises err and keeps the state.
module msi_next
    import msi_pkg::*;
(
    input  logic [ST_W-1:0] cur,
    input  logic [EV_W-1:0] ev,
    output logic [ST_W-1:0] nxt,
    output msi_act_t        act,
    output logic            err
);

    logic known;

    // Select the next state and strobes for the current state and event.
    always_comb begin
        act   = '0;
        nxt   = cur;
        known = 1'b1;
        case (cur)
            ST_I: begin
                case (ev)
                    EV_LOAD: begin
                        nxt = ST_IS_D;
                        act.line_alloc = 1'b1;
                        act.txn_alloc  = 1'b1;
                        act.req_gets   = 1'b1;
                        act.pop_cpu    = 1'b1;
                    end
                    EV_STORE: begin
                        nxt = ST_IM_AD;
                        act.line_alloc = 1'b1;
                        act.txn_alloc  = 1'b1;
                        act.req_getm   = 1'b1;
                        act.pop_cpu    = 1'b1;
                    end
                    default: known = 1'b0;
                endcase
            end
            ST_IS_D: begin
                case (ev)
                    EV_LOAD, EV_STORE, EV_REPL, EV_INV: act.stall = 1'b1;
                    EV_DATA_NA, EV_DATA_OW: begin
                        nxt = ST_S;
                        act.fill      = 1'b1;
                        act.txn_free  = 1'b1;
                        act.load_done = 1'b1;
                        act.pop_rsp   = 1'b1;
                    end
                    default: known = 1'b0;
                endcase
            end
            ST_IM_AD, ST_SM_AD: begin
                case (ev)
                    EV_LOAD: begin
                        if (cur == ST_SM_AD) begin
                            act.load_done = 1'b1;
                            act.pop_cpu   = 1'b1;
                        end else begin
                            act.stall = 1'b1;
                        end
                    end
                    EV_STORE, EV_REPL, EV_FWD_S, EV_FWD_M: act.stall = 1'b1;
                    EV_DATA_NA, EV_DATA_OW: begin
                        nxt = ST_M;
                        act.fill       = 1'b1;
                        act.txn_free   = 1'b1;
                        act.store_done = 1'b1;
                        act.pop_rsp    = 1'b1;
                    end
                    EV_DATA_A: begin
                        nxt = (cur == ST_SM_AD) ? ST_SM_A : ST_IM_A;
                        act.fill    = 1'b1;
                        act.pop_rsp = 1'b1;
                    end
                    EV_INV_ACK: act.pop_rsp = 1'b1;
                    EV_INV: begin
                        if (cur == ST_SM_AD) begin
                            nxt = ST_IM_AD;
                            act.inv_ack = 1'b1;
                            act.pop_fwd = 1'b1;
                        end else begin
                            known = 1'b0;
                        end
                    end
                    default: known = 1'b0;
                endcase
            end
            ST_IM_A, ST_SM_A: begin
                case (ev)
                    EV_LOAD: begin
                        if (cur == ST_SM_A) begin
                            act.load_done = 1'b1;
                            act.pop_cpu   = 1'b1;
                        end else begin
                            act.stall = 1'b1;
                        end
                    end
                    EV_STORE, EV_REPL, EV_FWD_S, EV_FWD_M: act.stall = 1'b1;
                    EV_INV_ACK: act.pop_rsp = 1'b1;
                    EV_LAST_IA: begin
                        nxt = ST_M;
                        act.txn_free   = 1'b1;
                        act.store_done = 1'b1;
                        act.pop_rsp    = 1'b1;
                    end
                    default: known = 1'b0;
                endcase
            end
            ST_S: begin
                case (ev)
                    EV_LOAD: begin
                        act.load_done = 1'b1;
                        act.pop_cpu   = 1'b1;
                    end
                    EV_STORE: begin
                        nxt = ST_SM_AD;
                        act.txn_alloc = 1'b1;
                        act.req_getm  = 1'b1;
                        act.pop_cpu   = 1'b1;
                    end
                    EV_REPL: begin
                        nxt = ST_SI_A;
                        act.req_puts = 1'b1;
                    end
                    EV_INV: begin
                        nxt = ST_I;
                        act.inv_ack   = 1'b1;
                        act.line_free = 1'b1;
                        act.pop_fwd   = 1'b1;
                    end
                    default: known = 1'b0;
                endcase
            end
            ST_M: begin
                case (ev)
                    EV_LOAD: begin
                        act.load_done = 1'b1;
                        act.pop_cpu   = 1'b1;
                    end
                    EV_STORE: begin
                        act.store_done = 1'b1;
                        act.pop_cpu    = 1'b1;
                    end
                    EV_REPL: begin
                        nxt = ST_MI_A;
                        act.req_putm = 1'b1;
                    end
                    EV_FWD_S: begin
                        nxt = ST_S;
                        act.data_req = 1'b1;
                        act.data_dir = 1'b1;
                        act.pop_fwd  = 1'b1;
                    end
                    EV_FWD_M: begin
                        nxt = ST_I;
                        act.data_req  = 1'b1;
                        act.line_free = 1'b1;
                        act.pop_fwd   = 1'b1;
                    end
                    default: known = 1'b0;
                endcase
            end
            ST_MI_A, ST_SI_A, ST_II_A: begin
                case (ev)
                    EV_LOAD, EV_STORE, EV_REPL: act.stall = 1'b1;
                    EV_PUT_ACK: begin
                        nxt = ST_I;
                        act.line_free = 1'b1;
                        act.pop_fwd   = 1'b1;
                    end
                    EV_FWD_S: begin
                        if (cur == ST_MI_A) begin
                            nxt = ST_SI_A;
                            act.data_req = 1'b1;
                            act.data_dir = 1'b1;
                            act.pop_fwd  = 1'b1;
                        end else begin
                            known = 1'b0;
                        end
                    end
                    EV_FWD_M: begin
                        if (cur == ST_MI_A) begin
                            nxt = ST_II_A;
                            act.data_req = 1'b1;
                            act.pop_fwd  = 1'b1;
                        end else begin
                            known = 1'b0;
                        end
                    end
                    EV_INV: begin
                        if (cur == ST_SI_A) begin
                            nxt = ST_II_A;
                            act.inv_ack = 1'b1;
                            act.pop_fwd = 1'b1;
                        end else begin
                            known = 1'b0;
                        end
                    end
                    default: known = 1'b0;
                endcase
            end
            default: known = 1'b0;
        endcase
        if (!known) begin
            act = '0;
            nxt = cur;
        end
        err = !known;
    end

endmodule

// File: rtl/msi_act_reg.sv
// Module: output register for the action strobes and the protocol error flag.
// Assumes one event per cycle; a cycle without an event clears every output.
module msi_act_reg
    import msi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  msi_act_t         act_d,
    input  logic             err_d,
    output logic             act_valid,
    output logic [ACT_W-1:0] act_o,
    output logic             proto_err
);

    // Capture the result of this cycle's event, or clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !ev_valid) begin
            act_valid <= 1'b0;
            act_o     <= '0;
            proto_err <= 1'b0;
        end else begin
            act_valid <= 1'b1;
            act_o     <= act_d;
            proto_err <= err_d;
        end
    end

endmodule

// File: rtl/msi_line_ctrl.sv
// Module: top of the MSI line coherence controller.
// Looks up the event's line, applies the transition function, writes the new state back
// and registers the strobes. Assumes at most one event per cycle.
module msi_line_ctrl
    import msi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [LINE_W-1:0] ev_line,
    input  logic [3:0]        ev_code,
    input  logic [LINE_W-1:0] qry_line,
    output logic              act_valid,
    output logic [17:0]       act_o,
    output logic              proto_err,
    output logic [3:0]        qry_state,
    output logic [1:0]        qry_perm
);

    logic [ST_W-1:0]           cur_st;
    logic [ST_W-1:0]           nxt_st;
    msi_act_t                  act_d;
    logic                      err_d;
    logic [NUM_LINES*ST_W-1:0] st_all;

    msi_state_array #(
        .NUM_LINES (NUM_LINES),
        .LINE_W    (LINE_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ev_valid),
        .wr_line   (ev_line),
        .wr_st     (nxt_st),
        .rd_a_line (ev_line),
        .rd_a_st   (cur_st),
        .rd_b_line (qry_line),
        .rd_b_st   (qry_state),
        .st_all    (st_all)
    );

    msi_next u_next (
        .cur (cur_st),
        .ev  (ev_code),
        .nxt (nxt_st),
        .act (act_d),
        .err (err_d)
    );

    msi_act_reg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (ev_valid),
        .act_d     (act_d),
        .err_d     (err_d),
        .act_valid (act_valid),
        .act_o     (act_o),
        .proto_err (proto_err)
    );

    // Permission of the queried line.
    always_comb qry_perm = perm_of(qry_state);

endmodule

// File: rtl/msi_line_ctrl_chk.sv
// Module: assertion checker for msi_line_ctrl, bound to every instance.
// Assumes the state vector of the top is visible as st_all.
module msi_line_ctrl_chk
    import msi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ev_valid,
    input logic [LINE_W-1:0]         ev_line,
    input logic                      act_valid,
    input logic [17:0]               act_o,
    input logic                      proto_err,
    input logic [NUM_LINES*ST_W-1:0] st_all
);

    logic [LINE_W-1:0] ln_d;
    logic [ST_W-1:0]   ln_st;

    // Remember which line the registered result belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) ln_d <= '0;
        else        ln_d <= ev_line;
    end

    // State of that line after its update.
    always_comb ln_st = st_all[int'(ln_d)*ST_W +: ST_W];

    p_result_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> act_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> (!act_valid && act_o == '0 && !proto_err));

    p_err_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (act_o == '0 && act_valid));

    p_stall_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        act_o[16] |-> $countones(act_o) == 1);

    p_one_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act_o[3:0]) <= 1);

    p_store_ends_in_m_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act_o[8] |-> ln_st == ST_M);

    p_load_readable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act_o[7] |-> perm_of(ln_st) != 2'd0);

endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (.*);

// File: tb/test_msi_line_ctrl.sv
// Bench: drives decoded events and compares every cycle against a behavioural model.
module test_msi_line_ctrl;

    localparam int NL = 4;
    localparam int LW = 2;

    localparam int S_I = 0, S_ISD = 1, S_IMAD = 2, S_IMA = 3, S_S = 4, S_SMAD = 5,
                   S_SMA = 6, S_M = 7, S_MIA = 8, S_SIA = 9, S_IIA = 10;
    localparam int E_LD = 0, E_ST = 1, E_RP = 2, E_FS = 3, E_FM = 4, E_INV = 5,
                   E_PA = 6, E_DNA = 7, E_DA = 8, E_DOW = 9, E_IA = 10, E_LIA = 11;
    localparam int A_GETS = 1 << 0, A_GETM = 1 << 1, A_PUTS = 1 << 2, A_PUTM = 1 << 3,
                   A_DREQ = 1 << 4, A_DDIR = 1 << 5, A_IACK = 1 << 6, A_LD = 1 << 7,
                   A_SD = 1 << 8, A_LA = 1 << 9, A_LF = 1 << 10, A_TA = 1 << 11,
                   A_TF = 1 << 12, A_PC = 1 << 13, A_PF = 1 << 14, A_PR = 1 << 15,
                   A_STL = 1 << 16, A_FILL = 1 << 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0;
    logic [LW-1:0] ev_line = '0;
    logic [3:0]    ev_code = '0;
    logic [LW-1:0] qry_line = '0;
    logic          act_valid;
    logic [17:0]   act_o;
    logic          proto_err;
    logic [3:0]    qry_state;
    logic [1:0]    qry_perm;

    int ref_st [NL];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    msi_line_ctrl #(.NUM_LINES(NL)) i_msi_line_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (ev_valid),
        .ev_line   (ev_line),
        .ev_code   (ev_code),
        .qry_line  (qry_line),
        .act_valid (act_valid),
        .act_o     (act_o),
        .proto_err (proto_err),
        .qry_state (qry_state),
        .qry_perm  (qry_perm)
    );

    task automatic chk(string tag, string what, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic int perm_exp(int s);
        if (s == S_M) return 2;
        if (s == S_S || s == S_SMAD || s == S_SMA) return 1;
        return 0;
    endfunction

    // Behavioural model, organised by event.
    task automatic model(input int s, input int e, output int ns, output int a,
                         output bit er, output string tg);
        ns = s; a = 0; er = 1'b0; tg = "R11";
        case (e)
            E_LD: begin
                if (s == S_I) begin ns = S_ISD; a = A_LA | A_TA | A_GETS | A_PC; tg = "R3"; end
                else if (s inside {S_S, S_SMAD, S_SMA, S_M}) begin a = A_LD | A_PC; tg = "R6"; end
                else begin a = A_STL; tg = "R10"; end
            end
            E_ST: begin
                if (s == S_I) begin ns = S_IMAD; a = A_LA | A_TA | A_GETM | A_PC; tg = "R3"; end
                else if (s == S_S) begin ns = S_SMAD; a = A_TA | A_GETM | A_PC; tg = "R7"; end
                else if (s == S_M) begin a = A_SD | A_PC; tg = "R6"; end
                else begin a = A_STL; tg = "R10"; end
            end
            E_RP: begin
                if (s == S_S) begin ns = S_SIA; a = A_PUTS; tg = "R7"; end
                else if (s == S_M) begin ns = S_MIA; a = A_PUTM; tg = "R8"; end
                else if (s != S_I) begin a = A_STL; tg = "R10"; end
                else er = 1'b1;
            end
            E_FS: begin
                if (s == S_M) begin ns = S_S; a = A_DREQ | A_DDIR | A_PF; tg = "R8"; end
                else if (s == S_MIA) begin ns = S_SIA; a = A_DREQ | A_DDIR | A_PF; tg = "R9"; end
                else if (s inside {S_IMAD, S_IMA, S_SMAD, S_SMA}) begin a = A_STL; tg = "R10"; end
                else er = 1'b1;
            end
            E_FM: begin
                if (s == S_M) begin ns = S_I; a = A_DREQ | A_LF | A_PF; tg = "R8"; end
                else if (s == S_MIA) begin ns = S_IIA; a = A_DREQ | A_PF; tg = "R9"; end
                else if (s inside {S_IMAD, S_IMA, S_SMAD, S_SMA}) begin a = A_STL; tg = "R10"; end
                else er = 1'b1;
            end
            E_INV: begin
                if (s == S_S) begin ns = S_I; a = A_IACK | A_LF | A_PF; tg = "R7"; end
                else if (s == S_SMAD) begin ns = S_IMAD; a = A_IACK | A_PF; tg = "R9"; end
                else if (s == S_SIA) begin ns = S_IIA; a = A_IACK | A_PF; tg = "R9"; end
                else if (s == S_ISD) begin a = A_STL; tg = "R10"; end
                else er = 1'b1;
            end
            E_PA: begin
                if (s inside {S_MIA, S_SIA, S_IIA}) begin ns = S_I; a = A_LF | A_PF; tg = "R9"; end
                else er = 1'b1;
            end
            E_DNA, E_DOW: begin
                if (s == S_ISD) begin ns = S_S; a = A_FILL | A_TF | A_LD | A_PR; tg = "R4"; end
                else if (s inside {S_IMAD, S_SMAD}) begin ns = S_M; a = A_FILL | A_TF | A_SD | A_PR; tg = "R4"; end
                else er = 1'b1;
            end
            E_DA: begin
                if (s == S_IMAD) begin ns = S_IMA; a = A_FILL | A_PR; tg = "R5"; end
                else if (s == S_SMAD) begin ns = S_SMA; a = A_FILL | A_PR; tg = "R5"; end
                else er = 1'b1;
            end
            E_IA: begin
                if (s inside {S_IMAD, S_IMA, S_SMAD, S_SMA}) begin a = A_PR; tg = "R5"; end
                else er = 1'b1;
            end
            E_LIA: begin
                if (s inside {S_IMA, S_SMA}) begin ns = S_M; a = A_TF | A_SD | A_PR; tg = "R5"; end
                else er = 1'b1;
            end
            default: er = 1'b1;
        endcase
    endtask

    // Read every line through the query port and compare with the model.
    task automatic check_lines(int ev_ln, string tag);
        for (int l = 0; l < NL; l++) begin
            qry_line = LW'(l);
            #1;
            chk((l == ev_ln) ? tag : "R13", "state", int'(qry_state), ref_st[l]);
            chk("R12", "perm", int'(qry_perm), perm_exp(ref_st[l]));
        end
    endtask

    // Present one event now (just after a falling edge); check one cycle later.
    task automatic do_ev(int ln, int code);
        int ns, a;
        bit er;
        string tg;
        model(ref_st[ln], code, ns, a, er, tg);
        ev_valid = 1'b1;
        ev_line  = LW'(ln);
        ev_code  = 4'(code);
        @(negedge clk);
        ev_valid = 1'b0;
        chk("R2", "act_valid", int'(act_valid), 1);
        chk(tg, "act_o", int'(act_o), a);
        chk(er ? "R11" : tg, "proto_err", int'(proto_err), int'(er));
        ref_st[ln] = ns;
        check_lines(ln, tg);
    endtask

    task automatic idle();
        @(negedge clk);
        chk("R2", "idle act_valid", int'(act_valid), 0);
        chk("R2", "idle act_o", int'(act_o), 0);
        chk("R2", "idle proto_err", int'(proto_err), 0);
        check_lines(-1, "R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < NL; l++) ref_st[l] = S_I;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset act_valid", int'(act_valid), 0);
        chk("R1", "reset act_o", int'(act_o), 0);
        chk("R1", "reset proto_err", int'(proto_err), 0);
        check_lines(-1, "R1");
        rst_n = 1'b1;
        idle();

        // Line 0: read miss, upgrade racing an Inv, acks, writeback race with Inv.
        do_ev(0, E_LD);  do_ev(0, E_LD);  do_ev(0, E_DNA); do_ev(0, E_LD);
        do_ev(0, E_ST);  do_ev(0, E_INV); do_ev(0, E_DA);  do_ev(0, E_IA);
        do_ev(0, E_FS);  do_ev(0, E_LIA); do_ev(0, E_ST);  do_ev(0, E_FS);
        do_ev(0, E_RP);  do_ev(0, E_INV); do_ev(0, E_LD);  do_ev(0, E_PA);
        idle();
        // Line 1: write miss, dirty eviction racing forwarded requests.
        do_ev(1, E_ST);  do_ev(1, E_DOW); do_ev(1, E_RP);  do_ev(1, E_FS);
        do_ev(1, E_PA);  do_ev(1, E_ST);  do_ev(1, E_DNA); do_ev(1, E_RP);
        do_ev(1, E_FM);  do_ev(1, E_ST);  do_ev(1, E_PA);  do_ev(1, E_ST);
        do_ev(1, E_DNA); do_ev(1, E_FM);
        // Line 2: protocol errors, upgrade with data only, shared invalidation.
        do_ev(2, E_PA);  do_ev(2, 13);    do_ev(2, E_LD);  do_ev(2, E_FM);
        do_ev(2, E_DOW); do_ev(2, E_FS);  do_ev(2, E_ST);  do_ev(2, E_LD);
        do_ev(2, E_DA);  do_ev(2, E_LD);  do_ev(2, E_ST);  do_ev(2, E_LIA);
        do_ev(3, E_LD);  do_ev(3, E_DNA); do_ev(3, E_INV); do_ev(3, E_IA);
        do_ev(3, E_ST);  do_ev(3, E_DNA); do_ev(3, E_RP);  do_ev(3, E_INV);
        idle();
        // Random event mix over all lines.
        for (int k = 0; k < 400; k++) begin
            do_ev($urandom_range(0, NL - 1), $urandom_range(0, 13));
        end
        idle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule